// File: doc/BRIEF.md
# Asymmetric Distance Lookup Accumulator

This block scores a stream of compressed database vectors against a single query. Before a query runs, the host fills four small local tables with partial distances. Each table belongs to one sub-quantizer, and each entry is an 8-bit unsigned value already quantized for that query. Because the tables are local, no lookup has to reach external memory.

Each database item then arrives as one packed 16-bit code. The block splits the code into sub-indices and reads one partial distance per sub-index. It adds the partial distances without any multiplier and returns a saturating total together with the tag that came with the code.

The code can be packed in one of two ways, and the host picks the packing with a configuration bit that is captured on every accepted table write. In the regular packing the code holds four 4-bit sub-indices. In the irregular packing it holds three sub-indices of 6, 5 and 5 bits, which together fill the 16-bit word exactly. The pipeline accepts one code per cycle. Table writes are refused while a code is being presented or a lookup is still in flight.

Top module: `pq_adc_accum`

## Requirements
- R1: With the regular packing (configuration bit 0), code bits [3:0], [7:4], [11:8] and [15:12] index tables 0, 1, 2 and 3 in that order. The distance is the sum of the four selected entries.
- R2: With the irregular packing (configuration bit 1), code bits [5:0] index table 0 (64 entries), bits [10:6] index table 1 (32 entries) and bits [15:11] index table 2 (32 entries). Table 3 contributes nothing.
- R3: When the sum exceeds 2^ACC_W-1, `out_dist` is 2^ACC_W-1. Otherwise it equals the sum exactly.
- R4: A code presented with `code_valid` high in cycle t produces `out_valid` high in cycle t+2. Back-to-back codes are accepted every cycle, and `out_valid` is never high without a matching code.
- R5: `out_tag` equals the `code_tag` that was presented with the same code.
- R6: An accepted write stores `wr_data` at entry `wr_idx` of table `wr_sub`. Codes presented after the write see the new value.
- R7: The packing is taken from `cfg_irregular` only on an accepted write. Changing `cfg_irregular` without a write does not change how later codes are decoded.
- R8: `wr_ready` is low while `code_valid` is high or a code is in the lookup stage. A write attempted while `wr_ready` is low leaves the tables and the packing unchanged.
- R9: After reset, `out_valid` is 0, `wr_ready` is 1 and the regular packing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_irregular | input | 1 | Packing select (0 regular, 1 irregular), captured on an accepted write |
| wr_en | input | 1 | Table write request |
| wr_sub | input | 2 | Table (sub-quantizer) number for the write |
| wr_idx | input | 6 | Entry number within the table |
| wr_data | input | ENTRY_W | Partial distance to store |
| wr_ready | output | 1 | High when a write would be accepted |
| code_valid | input | 1 | A code is presented this cycle |
| code | input | 16 | Packed sub-indices, least significant field first |
| code_tag | input | TAG_W | Item tag carried with the code |
| out_valid | output | 1 | Result valid |
| out_dist | output | ACC_W | Saturated distance |
| out_tag | output | TAG_W | Tag of the result |

## Verification
The bench drives every one of the 65536 codes through the block in each packing and checks every result cycle by cycle. A field boundary that is off by one bit, or a lane whose table is swapped with another, would therefore change some totals. A second instance with a 9-bit accumulator shows whether an overflowing sum clamps to the maximum or wraps to a small value. The bench attempts writes while a code is presented and while a lookup is still in flight, then reads back the affected entry. A design that let such a write through would return the overwritten value. The bench also toggles the packing input without issuing a write, which exposes a design that decodes the live input instead of the captured one.

// File: rtl/pq_adc_pkg.sv
package pq_adc_pkg;

  localparam int CODE_W = 16;
  localparam int NSUB   = 4;
  localparam int IDX_W  = 6;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int SUB_W  = $clog2(NSUB);

  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_IRR = 1'b1
  } pq_mode_e;

  // Index width of lane k; zero means the lane is unused in that packing.
  function automatic int lane_width(pq_mode_e m, int k);
    if (m == MODE_REG) return 4;
    if (k == 0) return 6;
    if (k < 3) return 5;
    return 0;
  endfunction

  // Lowest code bit of lane k; fields are packed upward from bit 0.
  function automatic int lane_lsb(pq_mode_e m, int k);
    if (m == MODE_REG) return 4 * k;
    if (k == 0) return 0;
    if (k == 1) return 6;
    if (k == 2) return 11;
    return CODE_W - 1;
  endfunction

endpackage

// File: rtl/pq_adc_unpack.sv
module pq_adc_unpack
  import pq_adc_pkg::*;
(
  input  pq_mode_e                     mode,
  input  logic [CODE_W-1:0]            code,
  output logic [NSUB-1:0][IDX_W-1:0]   idx,
  output logic [NSUB-1:0]              lane_en
);

  for (genvar k = 0; k < NSUB; k++) begin : g_lane
    int                w;
    int                lsb;
    logic [CODE_W-1:0] mask;
    always_comb begin
      w          = lane_width(mode, k);
      lsb        = lane_lsb(mode, k);
      mask       = (CODE_W'(1) << w) - CODE_W'(1);
      idx[k]     = IDX_W'((code >> lsb) & mask);
      lane_en[k] = (w != 0);
    end
  end

endmodule

// File: rtl/pq_adc_tables.sv
module pq_adc_tables
  import pq_adc_pkg::*;
#(
  parameter int ENTRY_W = 8
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [SUB_W-1:0]              wr_sub,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [ENTRY_W-1:0]            wr_data,
  input  logic                          rd_en,
  input  logic [NSUB-1:0][IDX_W-1:0]    rd_idx,
  output logic [NSUB-1:0][ENTRY_W-1:0]  rd_data
);

  for (genvar k = 0; k < NSUB; k++) begin : g_tab
    logic [ENTRY_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sub == SUB_W'(k))) mem[wr_idx] <= wr_data;
      if (rd_en) rd_data[k] <= mem[rd_idx[k]];
    end
  end

endmodule

// File: rtl/pq_adc_sum.sv
module pq_adc_sum
  import pq_adc_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int ACC_W   = 10,
  parameter int TAG_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [NSUB-1:0]               lane_en,
  input  logic [NSUB-1:0][ENTRY_W-1:0]  parts,
  input  logic [TAG_W-1:0]              in_tag,
  output logic                          sum_over,
  output logic                          out_valid,
  output logic [ACC_W-1:0]              out_dist,
  output logic [TAG_W-1:0]              out_tag
);

  localparam int RAW_W = ENTRY_W + $clog2(NSUB);
  localparam int SUM_W = ((RAW_W > ACC_W) ? RAW_W : ACC_W) + 1;
  localparam logic [SUM_W-1:0] CAP = {{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};

  logic [SUM_W-1:0] raw;

  always_comb begin
    raw = '0;
    for (int k = 0; k < NSUB; k++)
      if (lane_en[k]) raw = raw + SUM_W'(parts[k]);
  end

  assign sum_over = (raw > CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dist  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dist <= sum_over ? {ACC_W{1'b1}} : raw[ACC_W-1:0];
        out_tag  <= in_tag;
      end
    end
  end

endmodule

// File: rtl/pq_adc_accum.sv
module pq_adc_accum
  import pq_adc_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int ACC_W   = 10,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_irregular,
  input  logic               wr_en,
  input  logic [SUB_W-1:0]   wr_sub,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic               wr_ready,
  input  logic               code_valid,
  input  logic [CODE_W-1:0]  code,
  input  logic [TAG_W-1:0]   code_tag,
  output logic               out_valid,
  output logic [ACC_W-1:0]   out_dist,
  output logic [TAG_W-1:0]   out_tag
);

  pq_mode_e                     mode_q;
  logic                         wr_accept;
  logic                         s1_valid;
  logic [TAG_W-1:0]             s1_tag;
  logic [NSUB-1:0]              s1_lane_en;
  logic [NSUB-1:0][IDX_W-1:0]   lane_idx;
  logic [NSUB-1:0]              lane_en;
  logic [NSUB-1:0][ENTRY_W-1:0] parts;
  logic                         sum_over;

  // Writes wait until no code is presented and the lookup stage is empty.
  assign wr_ready  = !code_valid && !s1_valid;
  assign wr_accept = wr_en && wr_ready;

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= MODE_REG;
    else if (wr_accept) mode_q <= cfg_irregular ? MODE_IRR : MODE_REG;
  end

  pq_adc_unpack u_unpack (
    .mode    (mode_q),
    .code    (code),
    .idx     (lane_idx),
    .lane_en (lane_en)
  );

  pq_adc_tables #(.ENTRY_W(ENTRY_W)) u_tables (
    .clk     (clk),
    .wr_en   (wr_accept),
    .wr_sub  (wr_sub),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_en   (code_valid),
    .rd_idx  (lane_idx),
    .rd_data (parts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_tag     <= '0;
      s1_lane_en <= '0;
    end else begin
      s1_valid <= code_valid;
      if (code_valid) begin
        s1_tag     <= code_tag;
        s1_lane_en <= lane_en;
      end
    end
  end

  pq_adc_sum #(.ENTRY_W(ENTRY_W), .ACC_W(ACC_W), .TAG_W(TAG_W)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_valid),
    .lane_en   (s1_lane_en),
    .parts     (parts),
    .in_tag    (s1_tag),
    .sum_over  (sum_over),
    .out_valid (out_valid),
    .out_dist  (out_dist),
    .out_tag   (out_tag)
  );

endmodule

// File: rtl/pq_adc_accum_chk.sv
module pq_adc_accum_chk
  import pq_adc_pkg::*;
#(
  parameter int ACC_W = 10,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_irregular,
  input logic             wr_en,
  input logic             wr_accept,
  input logic             code_valid,
  input logic [TAG_W-1:0] code_tag,
  input logic             s1_valid,
  input logic             sum_over,
  input pq_mode_e         mode_q,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_dist,
  input logic [TAG_W-1:0] out_tag
);

  assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
    s1_valid && sum_over |=> &out_dist);

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> ##1 out_valid);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(code_valid, 2));

  assert_tag_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_tag == $past(code_tag, 2));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_accept |=> $stable(mode_q));

  assert_mode_take_R7: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> mode_q == ($past(cfg_irregular) ? MODE_IRR : MODE_REG));

  assert_holdoff_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en && (code_valid || s1_valid) |-> !wr_accept);

  assert_drained_R8: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> !out_valid);

endmodule

bind pq_adc_accum pq_adc_accum_chk #(.ACC_W(ACC_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/pq_adc_accum_test.sv
module pq_adc_accum_test;
  import pq_adc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRY_W    = 8;
  localparam int ACC_W      = 10;
  localparam int NARROW_W   = 9;
  localparam int TAG_W      = 8;
  localparam int WIDE_MAX   = (1 << ACC_W) - 1;
  localparam int NARROW_MAX = (1 << NARROW_W) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_irregular = 1'b0;
  logic               wr_en = 1'b0;
  logic [1:0]         wr_sub = '0;
  logic [5:0]         wr_idx = '0;
  logic [ENTRY_W-1:0] wr_data = '0;
  logic               code_valid = 1'b0;
  logic [15:0]        code = '0;
  logic [TAG_W-1:0]   code_tag = '0;

  logic                wr_ready, out_valid, nar_ready, nar_valid;
  logic [ACC_W-1:0]    out_dist;
  logic [NARROW_W-1:0] nar_dist;
  logic [TAG_W-1:0]    out_tag, nar_tag;

  pq_adc_accum #(.ENTRY_W(ENTRY_W), .ACC_W(ACC_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst), .cfg_irregular(cfg_irregular), .wr_en(wr_en),
    .wr_sub(wr_sub), .wr_idx(wr_idx), .wr_data(wr_data), .wr_ready(wr_ready),
    .code_valid(code_valid), .code(code), .code_tag(code_tag),
    .out_valid(out_valid), .out_dist(out_dist), .out_tag(out_tag));

  pq_adc_accum #(.ENTRY_W(ENTRY_W), .ACC_W(NARROW_W), .TAG_W(TAG_W)) uut_narrow (
    .clk(clk), .rst(rst), .cfg_irregular(cfg_irregular), .wr_en(wr_en),
    .wr_sub(wr_sub), .wr_idx(wr_idx), .wr_data(wr_data), .wr_ready(nar_ready),
    .code_valid(code_valid), .code(code), .code_tag(code_tag),
    .out_valid(nar_valid), .out_dist(nar_dist), .out_tag(nar_tag));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  int    model_tab [4][64];
  bit    model_irr = 1'b0;
  bit    hv [2] = '{0, 0};
  int    hexp [2] = '{0, 0};
  int    htag [2] = '{0, 0};

  function automatic int clamp(int v, int cap);
    return (v > cap) ? cap : v;
  endfunction

  // Bench-side decoding: field positions taken from R1 and R2.
  function automatic int ref_dist(int c);
    int s = 0;
    if (!model_irr) begin
      for (int k = 0; k < 4; k++) s += model_tab[k][(c / (1 << (4 * k))) % 16];
    end else begin
      s += model_tab[0][c % 64];
      s += model_tab[1][(c / 64) % 32];
      s += model_tab[2][(c / 2048) % 32];
    end
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One cycle: check what left the pipe, then drive the next inputs.
  task automatic step(bit v, int c, int t, bit we, int ws, int wi, int wd, bit cfg);
    bit acc;
    @(negedge clk);
    chk("R4", int'(out_valid), int'(hv[1]));
    chk("R4", int'(nar_valid), int'(hv[1]));
    chk("R8", int'(wr_ready), int'(!hv[0]));
    if (hv[1]) begin
      chk(cur_req, int'(out_dist), clamp(hexp[1], WIDE_MAX));
      chk("R3", int'(nar_dist), clamp(hexp[1], NARROW_MAX));
      chk("R5", int'(out_tag), htag[1]);
    end
    acc = we && !v && !hv[0];
    hv[1] = hv[0]; hexp[1] = hexp[0]; htag[1] = htag[0];
    hv[0] = v; hexp[0] = v ? ref_dist(c) : 0; htag[0] = t;
    if (acc) begin
      model_tab[ws][wi] = wd;
      model_irr = cfg;
    end
    code_valid    = v;
    code          = 16'(c);
    code_tag      = TAG_W'(t);
    wr_en         = we;
    wr_sub        = 2'(ws);
    wr_idx        = 6'(wi);
    wr_data       = ENTRY_W'(wd);
    cfg_irregular = cfg;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, model_irr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 64; i++) model_tab[s][i] = 0;
    repeat (3) @(negedge clk);
    chk("R9", int'(out_valid), 0);
    chk("R9", int'(wr_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", int'(wr_ready), 1);

    // R6: fill every entry of every table.
    cur_req = "R6";
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 64; i++) step(0, 0, 0, 1, s, i, (s * 53 + i * 29 + 7) % 256, 0);

    // R1: full sweep of codes in the regular packing.
    cur_req = "R1";
    for (int c = 0; c < 65536; c++) step(1, c, (c ^ 90) % 256, 0, 0, 0, 0, 0);
    idle(2);

    // R7: capture irregular packing with a write, then R2 sweep.
    step(0, 0, 0, 1, 3, 0, model_tab[3][0], 1);
    cur_req = "R2";
    for (int c = 0; c < 65536; c++) step(1, c, (c * 7) % 256, 0, 0, 0, 0, 1);
    idle(2);

    // R7: flip the packing input without a write; decoding must not change.
    cur_req = "R7";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    for (int c = 0; c < 32; c++) step(1, c * 1031 + 5, c, 0, 0, 0, 0, 0);
    idle(2);

    // R8: writes during a presented code and during an in-flight lookup.
    cur_req = "R8";
    step(1, 5, 1, 1, 0, 5, 200, 0);
    step(0, 0, 0, 1, 0, 5, 201, 0);
    idle(2);
    step(1, 5, 2, 0, 0, 0, 0, 1);
    step(1, 16'hFFFF, 3, 0, 0, 0, 0, 1);
    idle(2);

    // R6: single entry update seen by the next code.
    cur_req = "R6";
    step(0, 0, 0, 1, 2, 31, 255, 1);
    step(1, 31 * 2048, 4, 0, 0, 0, 0, 1);
    idle(2);

    // R3: regular packing, all-ones code hitting entries of 255.
    cur_req = "R3";
    for (int s = 0; s < 4; s++) step(0, 0, 0, 1, s, 15, 255, 0);
    step(1, 16'hFFFF, 5, 0, 0, 0, 0, 0);
    step(1, 0, 6, 0, 0, 0, 0, 0);
    idle(3);

    summary();
    $finish;
  end

endmodule